// File: doc/BRIEF.md
# Serial Quad-DAC Register Front End

This block is the digital side of a four-channel, 8-bit digital-to-analog converter that is programmed over a three-wire serial link made of an active-low select, a serial clock and a data line. The link pins are sampled by a faster system clock, and their edges are detected synchronously, so the design has no gated clocks. A frame of 12 bits is shifted in while select is low. When select rises, the frame is committed: its data byte goes to the input register of the addressed channel, and its two active-low shutdown flags update the power-down state.

Each channel has two registers in series: an input register that is written by frames, and a DAC register that drives the channel's code output. A level-sensitive load strobe copies all four input registers into the DAC registers for as long as the strobe is low. A clear input forces every input and DAC register to zero for as long as it is low. When clear is released, those zeros stay in place. An external force-off input stands in for floated-pin detection and powers down every channel while it is asserted.

Top module: `qdac_serial_front`

## Requirements
- R1: A frame has the layout bit 11 = all-off flag (active low), bit 10 = channel-off flag (active low), bits 9:8 = channel address, and bits 7:0 = data. It is sent MSB first. On the rising edge of select, the data byte is written to the input register of the addressed channel, where 0 is channel A, 1 is B, 2 is C and 3 is D. `dac_code` packs the channels as A in bits 7:0, then B, then C, then D in bits 31:24.
- R2: While select is high, edges on the serial clock and changes on the data line change no register.
- R3: If a select-low period delivers fewer than 12 clock rises, it is discarded, and no register or shutdown state changes.
- R4: If a select-low period delivers more than 12 clock rises, the last 12 bits received are committed as the frame.
- R5: While load is high, the DAC registers hold their values, even when input registers are rewritten.
- R6: While load is low, each DAC register follows its input register. This includes writes that happen during the low period.
- R7: While clear is low, all input and DAC registers are zero, and frames that complete in that time are ignored. After clear rises, the registers stay at zero until they are rewritten.
- R8: A committed frame with the all-off flag at 0 shuts down every channel. A committed frame with the flag at 1 cancels the global shutdown.
- R9: A committed frame with the channel-off flag at 0 shuts down only the addressed channel. A committed frame with the flag at 1 re-enables that channel.
- R10: While `force_off` is high, every bit of `chan_off` is 1, in the same cycle and without a clock.
- R11: After reset, every DAC code is zero and no channel is shut down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all link pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Level-sensitive transfer strobe, active low |
| clear_n | input | 1 | Clear to zero, active low |
| force_off | input | 1 | External request to shut down all channels |
| dac_code | output | 32 | Four 8-bit DAC register values, channel A in the low byte |
| chan_off | output | 4 | Per-channel shutdown indication, bit 0 = channel A |

## Verification
Four kinds of wrong internal state show up at the ports. A wrong bit count or shift order writes the wrong byte or the wrong channel. A missed select edge drops a frame. A broken transfer path lets `dac_code` drift while load is high, or keeps it frozen while load is low. A stuck shutdown flag shows on `chan_off`. The link is sampled through two synchronizer stages and one edge stage, so any such fault reaches `dac_code` or `chan_off` within about five system clocks of the link edge that triggered it. The bench therefore samples several cycles after each stimulus. Input-register contents are made visible by pulsing load low.

// File: rtl/qdac_pkg.sv
// Package: shared widths of the serial quad-DAC front end.
// Assumes the frame is two flags, then address, then data, MSB first.
package qdac_pkg;
    localparam int CH_N    = 4;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = $clog2(CH_N);
    localparam int FRAME_W = 2 + ADDR_W + DATA_W;
    localparam int ALL_BIT = FRAME_W - 1;
    localparam int CHN_BIT = FRAME_W - 2;
    localparam int SYNC_W  = 5;
endpackage

// File: rtl/qdac_sync.sv
// Module: qdac_sync
// Two-stage synchronizer plus one edge stage for a bundle of
// asynchronous pins. Gives the level and one-cycle rise/fall pulses.
// Assumes each pin is stable for several system clocks per level.
module qdac_sync #(
    parameter int            W       = 5,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    // Shift the pins through the synchronizer and edge stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
            s3_q <= RST_VAL;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Derive level and edge pulses.
    always_comb begin
        lvl_o  = s2_q;
        rise_o = s2_q & ~s3_q;
        fall_o = ~s2_q & s3_q;
    end
endmodule

// File: rtl/qdac_shifter.sv
// Module: qdac_shifter
// Collects serial bits while select is low and raises commit for one
// cycle after select rises, if at least FRAME_W bits arrived.
// Assumes synchronized inputs; longer frames keep the newest bits.
module qdac_shifter
    import qdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_lvl,
    input  logic               cs_rise,
    input  logic               cs_fall,
    input  logic               sclk_rise,
    input  logic               sdin,
    output logic [FRAME_W-1:0] frame_o,
    output logic               commit_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               commit_q;

    // Shift on each qualified clock rise; count bits, saturating at FULL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
        end else if (!cs_lvl && sclk_rise) begin
            sr_q <= {sr_q[FRAME_W-2:0], sdin};
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Issue the commit pulse when select rises after a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= cs_rise && (cnt_q == FULL);
    end

    assign frame_o  = sr_q;
    assign commit_o = commit_q;
endmodule

// File: rtl/qdac_regbank.sv
// Module: qdac_regbank
// Input and DAC register pairs for every channel, plus the global and
// per-channel shutdown flags. Clear wins over load and over commits.
// Assumes commit is a single-cycle pulse and the frame is stable while it is high.
module qdac_regbank
    import qdac_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_lvl,
    input  logic                          load_lvl,
    input  logic                          commit,
    input  logic [FRAME_W-1:0]            frame,
    output logic [CH_N-1:0][DATA_W-1:0]   in_q,
    output logic [CH_N-1:0][DATA_W-1:0]   dac_q,
    output logic                          sd_all_q,
    output logic [CH_N-1:0]               sd_ch_q
);
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              accept;

    // Split the frame into its fields.
    always_comb begin
        addr   = frame[DATA_W +: ADDR_W];
        data   = frame[DATA_W-1:0];
        accept = commit && clr_lvl;
    end

    // Global shutdown flag, set by a low all-off bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      sd_all_q <= 1'b0;
        else if (accept) sd_all_q <= ~frame[ALL_BIT];
    end

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        // Input register: cleared, or written by an addressed frame.
        always_ff @(posedge clk) begin
            if (!rst_n || !clr_lvl)                      in_q[g] <= '0;
            else if (accept && addr == ADDR_W'(g))       in_q[g] <= data;
        end

        // DAC register: cleared, or transparent while load is low.
        always_ff @(posedge clk) begin
            if (!rst_n || !clr_lvl) dac_q[g] <= '0;
            else if (!load_lvl)     dac_q[g] <= in_q[g];
        end

        // Per-channel shutdown, set by a low channel-off bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  sd_ch_q[g] <= 1'b0;
            else if (accept && addr == ADDR_W'(g))       sd_ch_q[g] <= ~frame[CHN_BIT];
        end
    end
endmodule

// File: rtl/qdac_serial_front.sv
// Module: qdac_serial_front (top)
// Serial front end of a four-channel DAC: synchronizes the link pins,
// assembles frames, and drives double-buffered codes and shutdown flags.
// Assumes link pins change slowly relative to clk.
module qdac_serial_front
    import qdac_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_cs_n,
    input  logic                       ser_clk,
    input  logic                       ser_din,
    input  logic                       load_n,
    input  logic                       clear_n,
    input  logic                       force_off,
    output logic [CH_N*DATA_W-1:0]     dac_code,
    output logic [CH_N-1:0]            chan_off
);
    // Pin order: 0 cs, 1 sclk, 2 din, 3 load, 4 clear.
    localparam logic [SYNC_W-1:0] PIN_RST = 5'b11001;

    logic [SYNC_W-1:0] lvl, rise, fall;
    logic [FRAME_W-1:0] frame;
    logic commit;
    logic [CH_N-1:0][DATA_W-1:0] in_q, dac_q;
    logic sd_all_q;
    logic [CH_N-1:0] sd_ch_q;

    qdac_sync #(.W(SYNC_W), .RST_VAL(PIN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_i({clear_n, load_n, ser_din, ser_clk, ser_cs_n}),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    qdac_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(lvl[0]), .cs_rise(rise[0]), .cs_fall(fall[0]),
        .sclk_rise(rise[1]), .sdin(lvl[2]),
        .frame_o(frame), .commit_o(commit)
    );

    qdac_regbank u_bank (
        .clk(clk), .rst_n(rst_n),
        .clr_lvl(lvl[4]), .load_lvl(lvl[3]),
        .commit(commit), .frame(frame),
        .in_q(in_q), .dac_q(dac_q),
        .sd_all_q(sd_all_q), .sd_ch_q(sd_ch_q)
    );

    // Drive the outputs; force_off acts without a clock.
    always_comb begin
        dac_code = dac_q;
        chan_off = sd_ch_q | {CH_N{sd_all_q | force_off}};
    end
endmodule

// File: rtl/qdac_chk.sv
// Module: qdac_chk
// Assertion checker for qdac_serial_front, attached with bind.
module qdac_chk
    import qdac_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        clr_lvl,
    input logic                        load_lvl,
    input logic                        commit,
    input logic [FRAME_W-1:0]          frame,
    input logic [CH_N-1:0][DATA_W-1:0] in_q,
    input logic [CH_N-1:0][DATA_W-1:0] dac_q,
    input logic                        force_off,
    input logic [CH_N-1:0]             chan_off
);
    // R10
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> (chan_off == {CH_N{1'b1}}));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl |=> (dac_q == '0 && in_q == '0));

    // R5
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lvl && clr_lvl) |=> $stable(dac_q));

    // R6
    load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_lvl && clr_lvl) |=> (dac_q == $past(in_q)));

    // R1
    commit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && clr_lvl) |=>
            (in_q[$past(frame[DATA_W +: ADDR_W])] == $past(frame[DATA_W-1:0])));
endmodule

bind qdac_serial_front qdac_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .clr_lvl(lvl[4]), .load_lvl(lvl[3]),
    .commit(commit), .frame(frame),
    .in_q(in_q), .dac_q(dac_q),
    .force_off(force_off), .chan_off(chan_off)
);

// File: tb/sim_qdac_serial_front.sv
// Directed bench for qdac_serial_front: one task per scenario.
module sim_qdac_serial_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
    logic load_n = 1'b1, clear_n = 1'b1, force_off = 1'b0;
    logic [31:0] dac_code;
    logic [3:0]  chan_off;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    logic [7:0] m_in [4];
    logic [7:0] m_dac [4];
    logic       m_all;
    logic [3:0] m_ch;

    always #4 clk = ~clk;

    qdac_serial_front u0 (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .load_n(load_n), .clear_n(clear_n),
        .force_off(force_off), .dac_code(dac_code), .chan_off(chan_off)
    );

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_code();
        return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
    endfunction

    function automatic logic [3:0] exp_off();
        return m_ch | {4{m_all | force_off}};
    endfunction

    task automatic chk_all(input string tag);
        waitc(10);
        chk({tag, " code"}, dac_code, exp_code());
        chk({tag, " off"}, {28'd0, chan_off}, {28'd0, exp_off()});
    endtask

    // Model a committed frame.
    task automatic model_frame(input logic [11:0] f);
        if (clear_n) begin
            m_in[f[9:8]] = f[7:0];
            m_all = ~f[11];
            m_ch[f[9:8]] = ~f[10];
        end
        if (!load_n) for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    endtask

    // Shift n bits of v, MSB first, inside one select-low period.
    task automatic send_bits(input logic [15:0] v, input int n);
        ser_cs_n = 1'b0;
        waitc(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = v[i];
            waitc(4);
            ser_clk = 1'b1;
            waitc(4);
            ser_clk = 1'b0;
        end
        waitc(4);
        ser_cs_n = 1'b1;
        waitc(8);
    endtask

    task automatic send_frame(input logic [11:0] f);
        send_bits({4'd0, f}, 12);
        model_frame(f);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        waitc(8);
        for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
        load_n = 1'b1;
        waitc(8);
    endtask

    task automatic t_reset();
        chk_all("R11 reset");
    endtask

    task automatic t_hold_then_load();
        send_frame({2'b11, 2'd0, 8'h5A});
        send_frame({2'b11, 2'd1, 8'hC3});
        send_frame({2'b11, 2'd2, 8'h0F});
        send_frame({2'b11, 2'd3, 8'hF0});
        chk_all("R5 hold while load high");
        pulse_load();
        chk_all("R1 address map after load");
    endtask

    task automatic t_transparent();
        load_n = 1'b0;
        waitc(8);
        send_frame({2'b11, 2'd2, 8'h3C});
        chk_all("R6 transparent write");
        load_n = 1'b1;
        waitc(8);
        send_frame({2'b11, 2'd2, 8'h99});
        chk_all("R5 held after load high");
    endtask

    task automatic t_cs_high();
        load_n = 1'b0;
        waitc(8);
        for (int i = 0; i < 14; i++) begin
            ser_din = i[0];
            waitc(4);
            ser_clk = 1'b1;
            waitc(4);
            ser_clk = 1'b0;
        end
        for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
        chk_all("R2 clocks with select high");
        load_n = 1'b1;
        waitc(8);
    endtask

    task automatic t_short();
        send_bits({4'd0, 2'b00, 2'd3, 8'h11}, 11);
        pulse_load();
        chk_all("R3 short frame discarded");
    endtask

    task automatic t_long();
        send_bits({2'b10, 2'b11, 2'd3, 8'hA5}, 14);
        model_frame({2'b11, 2'd3, 8'hA5});
        pulse_load();
        chk_all("R4 long frame keeps last 12");
    endtask

    task automatic t_clear();
        clear_n = 1'b0;
        waitc(8);
        for (int i = 0; i < 4; i++) begin m_in[i] = 8'h00; m_dac[i] = 8'h00; end
        chk_all("R7 clear zeros");
        send_frame({2'b11, 2'd0, 8'h77});
        load_n = 1'b0;
        waitc(8);
        chk_all("R7 frame ignored in clear");
        load_n = 1'b1;
        clear_n = 1'b1;
        waitc(8);
        pulse_load();
        chk_all("R7 zeros kept after clear");
    endtask

    task automatic t_shutdown();
        send_frame({2'b01, 2'd1, 8'h12});
        chk_all("R8 all-off set");
        send_frame({2'b11, 2'd1, 8'h12});
        chk_all("R8 all-off cancelled");
        send_frame({2'b10, 2'd2, 8'h34});
        chk_all("R9 channel C off");
        send_frame({2'b11, 2'd2, 8'h34});
        chk_all("R9 channel C on");
    endtask

    task automatic t_force();
        send_frame({2'b10, 2'd0, 8'h01});
        force_off = 1'b1;
        #1;
        chk("R10 force off", {28'd0, chan_off}, 32'hF);
        force_off = 1'b0;
        #1;
        chk("R10 force released", {28'd0, chan_off}, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_in[i] = 8'h00; m_dac[i] = 8'h00; end
        m_all = 1'b0;
        m_ch  = 4'h0;
        waitc(5);
        rst_n = 1'b1;
        waitc(2);
        t_reset();
        t_hold_then_load();
        t_transparent();
        t_cs_high();
        t_short();
        t_long();
        t_clear();
        t_shutdown();
        t_force();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule